// File: doc/BRIEF.md
# Sample FIFO with Threshold Interrupt

This block buffers tagged conversion samples between a scan sequencer and a host bus. The sequencer pushes 16-bit words into a 512-deep synchronous store. The host pops them one at a time, and each popped word appears on a registered output. The block reports its occupancy as a 10-bit count and raises a full flag and a half-full flag. It also raises a level interrupt whenever occupancy reaches a host-programmed threshold, and the interrupt drops by itself once occupancy falls back below that threshold.

The block also keeps a head index, the scan position of the word now at the FIFO output. The index is set to zero when a word enters an empty FIFO. It steps by one on every accepted pop and wraps to zero after it reaches the programmed last scan position. A synchronous clear input empties the FIFO in one cycle without touching the configuration.

A fill state machine governs pushes and pops. It has three states:

- **ST_EMPTY**: no words are held.
- **ST_PARTIAL**: between 1 and 511 words are held.
- **ST_FULL**: 512 words are held.

It has four transitions, and the clear input forces any state back to ST_EMPTY:

- **FIRST_WORD** (ST_EMPTY to ST_PARTIAL): an accepted push.
- **FILL_UP** (ST_PARTIAL to ST_FULL): a push alone at count 511.
- **DRAIN_OUT** (ST_PARTIAL to ST_EMPTY): a pop alone at count 1.
- **LEAVE_FULL** (ST_FULL to ST_PARTIAL): an accepted pop.

Top module: `smpl_fifo_irq`

## Requirements
- R1: Words leave in the order they entered. The word taken by an accepted pop is on `pop_data` from the clock edge that samples the pop until the next accepted pop. `pop_data` resets to 0.
- R2: `full` is 1 exactly when `count` equals 512.
- R3: `half_full` is 1 exactly when `count` is 256 or more.
- R4: A push while `count` is 512 is dropped, and the stored words stay as they were. A pop while `count` is 0 is ignored: `count` stays 0 and `pop_data` keeps its value.
- R5: `count` changes by the number of accepted pushes minus the number of accepted pops. A push and a pop in the same cycle with 0 < `count` < 512 leave `count` unchanged.
- R6: The 10-bit threshold resets to 256. A cycle with `thr_we` high loads `thr_wdata` into it.
- R7: With the interrupt enabled, `irq` is 1 exactly when `count` >= threshold, in the same cycle as `count`.
- R8: The interrupt enable resets to 0. A cycle with `ien_we` high loads `ien_wdata` into it. While the enable is 0, `irq` is 0.
- R9: An accepted push into an empty FIFO sets `head_idx` to 0. Each accepted pop then adds 1, except that a pop with `head_idx` equal to `last_pos` sets it to 0.
- R10: `clear` sets `count`, both pointers and `head_idx` to 0 at the next edge. It takes precedence over a push or pop in the same cycle, and it leaves the threshold, the enable and `pop_data` unchanged.
- R11: After reset, `count`, `full`, `half_full`, `irq` and `head_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous empty command |
| push | input | 1 | Write strobe from the sequencer |
| push_data | input | 16 | Word to store |
| pop | input | 1 | Read strobe from the host |
| pop_data | output | 16 | Last word popped |
| thr_we | input | 1 | Load strobe for the threshold |
| thr_wdata | input | 10 | New threshold |
| ien_we | input | 1 | Load strobe for the interrupt enable |
| ien_wdata | input | 1 | New interrupt enable |
| last_pos | input | 5 | Last scan position before the head index wraps |
| count | output | 10 | Occupancy, 0 to 512 |
| full | output | 1 | Occupancy is 512 |
| half_full | output | 1 | Occupancy is 256 or more |
| irq | output | 1 | Level interrupt |
| head_idx | output | 5 | Scan position of the word at the output |

## Verification
The properties assume the inputs are known after reset, and that a cycle with `clear` high is not also counted as an accepted push or pop. The properties exclude that case by their own guard terms. The random stimulus draws each strobe as a known bit from a seeded generator, and it biases push against pop in separate phases so that the FIFO fills to full, drains to empty and sits in between. Because `last_pos` changes only between phases, the head index stays inside the programmed scan length for most of the run. Directed sequences then press on the full and empty boundaries, the threshold edge and the wrap of the head index.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_t;

endpackage

// File: rtl/sfq_store.sv
module sfq_store #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/sfq_ctrl.sv
module sfq_ctrl
    import sfq_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    output logic          wr_en,
    output logic          rd_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          half_full,
    output logic          empty
);

    localparam logic [CW-1:0] LAST_SLOT = CW'(DEPTH - 1);
    localparam logic [CW-1:0] HALF_MARK = CW'(DEPTH / 2);
    localparam logic [CW-1:0] TOP_MARK  = CW'(DEPTH);

    fill_state_t state, nxt_state;
    logic push_ok, pop_ok;

    // a cycle with clear set accepts neither a push nor a pop
    assign push_ok = push && (state != ST_FULL)  && !clear;
    assign pop_ok  = pop  && (state != ST_EMPTY) && !clear;

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_EMPTY: begin
                if (push_ok) nxt_state = ST_PARTIAL;             // FIRST_WORD
            end
            ST_PARTIAL: begin
                if (push_ok && !pop_ok && count == LAST_SLOT)
                    nxt_state = ST_FULL;                         // FILL_UP
                else if (pop_ok && !push_ok && count == CW'(1))
                    nxt_state = ST_EMPTY;                        // DRAIN_OUT
            end
            ST_FULL: begin
                if (pop_ok) nxt_state = ST_PARTIAL;              // LEAVE_FULL
            end
            default: nxt_state = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= ST_EMPTY;
        else if (clear)  state <= ST_EMPTY;
        else             state <= nxt_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clear) begin
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            if (push_ok && !pop_ok)      count <= count + CW'(1);
            else if (pop_ok && !push_ok) count <= count - CW'(1);
        end
    end

    always_comb begin
        full      = (state == ST_FULL);
        empty     = (state == ST_EMPTY);
        half_full = (count >= HALF_MARK);
        wr_en     = push_ok;
        rd_en     = pop_ok;
    end

    // R2
    full_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full == (count == TOP_MARK));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TOP_MARK);

    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clear && count == '0) |=> (count == '0));

    // R5
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !clear && count != '0 && count != TOP_MARK) |=> $stable(count));

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && wr_ptr == '0 && rd_ptr == '0 && empty));

endmodule

// File: rtl/sfq_head.sv
module sfq_head #(
    parameter int POS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             first_push,
    input  logic             pop_ok,
    input  logic [POS_W-1:0] last_pos,
    output logic [POS_W-1:0] head_idx
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_idx <= '0;
        end else if (clear || first_push) begin
            head_idx <= '0;
        end else if (pop_ok) begin
            head_idx <= (head_idx == last_pos) ? '0 : head_idx + POS_W'(1);
        end
    end

    // R9
    head_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_push && !clear) |=> (head_idx == '0));

    // R9
    head_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !clear && !first_push && head_idx == last_pos) |=> (head_idx == '0));

endmodule

// File: rtl/smpl_fifo_irq.sv
module smpl_fifo_irq #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 16,
    parameter int POS_W  = 5,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    input  logic              thr_we,
    input  logic [CW-1:0]     thr_wdata,
    input  logic              ien_we,
    input  logic              ien_wdata,
    input  logic [POS_W-1:0]  last_pos,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              half_full,
    output logic              irq,
    output logic [POS_W-1:0]  head_idx
);

    localparam logic [CW-1:0] THR_RESET = CW'(DEPTH / 2);

    logic          wr_en, rd_en, empty;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] thr_q;
    logic          ien_q;

    sfq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push      (push),
        .pop       (pop),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (count),
        .full      (full),
        .half_full (half_full),
        .empty     (empty)
    );

    sfq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_ptr),
        .wr_data (push_data),
        .rd_en   (rd_en),
        .rd_addr (rd_ptr),
        .rd_data (pop_data)
    );

    sfq_head #(.POS_W(POS_W)) u_head (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .first_push (wr_en && empty),
        .pop_ok     (rd_en),
        .last_pos   (last_pos),
        .head_idx   (head_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= THR_RESET;
            ien_q <= 1'b0;
        end else begin
            if (thr_we) thr_q <= thr_wdata;
            if (ien_we) ien_q <= ien_wdata;
        end
    end

    assign irq = ien_q && (count >= thr_q);

    // R7
    irq_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count < thr_q) |-> !irq);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_we && !ien_wdata) |=> !irq);

    // R3
    half_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half_full);

endmodule

// File: tb/smpl_fifo_irq_bench.sv
module smpl_fifo_irq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        push = 1'b0;
    logic [15:0] push_data = '0;
    logic        pop = 1'b0;
    logic [15:0] pop_data;
    logic        thr_we = 1'b0;
    logic [9:0]  thr_wdata = '0;
    logic        ien_we = 1'b0;
    logic        ien_wdata = 1'b0;
    logic [4:0]  last_pos = 5'd23;
    logic [9:0]  count;
    logic        full, half_full, irq;
    logic [4:0]  head_idx;

    always #5 clk = ~clk;

    smpl_fifo_irq u_smpl_fifo_irq (
        .clk(clk), .rst_n(rst_n), .clear(clear), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pop_data), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .ien_we(ien_we), .ien_wdata(ien_wdata), .last_pos(last_pos), .count(count),
        .full(full), .half_full(half_full), .irq(irq), .head_idx(head_idx)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] q[$];
    int          m_thr = 256;
    bit          m_en = 1'b0;
    int          m_head = 0;
    logic [15:0] m_out = '0;

    function automatic bit exp_full(int n);
        return n == 512;
    endfunction

    function automatic bit exp_half(int n);
        return n >= 256;
    endfunction

    function automatic bit exp_irq(int n, int t, bit e);
        return e && (n >= t);
    endfunction

    function automatic int next_head(int h, int last);
        return (h == last) ? 0 : ((h + 1) % 32);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R5 count", int'(count), q.size());
        chk("R2 full", int'(full), int'(exp_full(q.size())));
        chk("R3 half_full", int'(half_full), int'(exp_half(q.size())));
        chk("R7 irq", int'(irq), int'(exp_irq(q.size(), m_thr, m_en)));
        chk("R9 head_idx", int'(head_idx), m_head);
        chk("R1 pop_data", int'(pop_data), int'(m_out));
    endtask

    // one clock: inputs already driven at the falling edge
    task automatic step();
        int  n;
        bit  pa, qa;
        @(posedge clk);
        n  = q.size();
        pa = push && (n < 512) && !clear;
        qa = pop && (n > 0) && !clear;
        if (clear) begin
            q.delete();
            m_head = 0;
        end else begin
            if (qa) begin
                m_out  = q.pop_front();
                m_head = next_head(m_head, int'(last_pos));
            end
            if (pa) begin
                if (n == 0) m_head = 0;
                q.push_back(push_data);
            end
        end
        if (thr_we) m_thr = int'(thr_wdata);
        if (ien_we) m_en = ien_wdata;
        @(negedge clk);
        check_all();
        push = 1'b0; pop = 1'b0; clear = 1'b0; thr_we = 1'b0; ien_we = 1'b0;
    endtask

    task automatic drive(bit pu, bit po, logic [15:0] d);
        push = pu; pop = po; push_data = d;
        step();
    endtask

    initial begin
        #1500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 count", int'(count), 0);
        chk("R11 full", int'(full), 0);
        chk("R11 half_full", int'(half_full), 0);
        chk("R11 irq", int'(irq), 0);
        chk("R11 head_idx", int'(head_idx), 0);
        chk("R1 reset pop_data", int'(pop_data), 0);

        // R8: enable only, threshold stays at its reset value (R6)
        ien_we = 1'b1; ien_wdata = 1'b1;
        step();
        for (int i = 0; i < 255; i++) drive(1'b1, 1'b0, 16'(i * 7 + 1));
        chk("R6 below default threshold", int'(irq), 0);
        drive(1'b1, 1'b0, 16'hA5A5);
        chk("R6 default threshold 256", int'(irq), 1);
        for (int i = 0; i < 256; i++) drive(1'b1, 1'b0, 16'(i ^ 16'h3C00));
        chk("R2 full at 512", int'(full), 1);
        // R4 push while full dropped
        drive(1'b1, 1'b0, 16'hDEAD);
        chk("R4 push while full", int'(count), 512);
        // push and pop at full: only the pop is accepted
        drive(1'b1, 1'b1, 16'hBEEF);
        chk("R4 pair at full", int'(count), 511);
        chk("R1 first word out", int'(pop_data), 1);
        // R8 disable masks the interrupt
        ien_we = 1'b1; ien_wdata = 1'b0;
        step();
        chk("R8 disabled irq", int'(irq), 0);
        // drain fully
        for (int i = 0; i < 511; i++) drive(1'b0, 1'b1, '0);
        chk("R5 drained", int'(count), 0);
        // R4 pop while empty
        drive(1'b0, 1'b1, '0);
        chk("R4 pop empty keeps data", int'(pop_data), int'(m_out));
        chk("R4 pop empty count", int'(count), 0);

        // R9 head wrap with a short scan
        last_pos = 5'd2;
        for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, 16'(16'h100 + i));
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, '0);
        chk("R9 wrapped head", int'(head_idx), 1);

        // R6 program threshold 5, R7 follows it
        thr_we = 1'b1; thr_wdata = 10'd5; ien_we = 1'b1; ien_wdata = 1'b1;
        step();
        chk("R7 at threshold", int'(irq), 0);
        drive(1'b1, 1'b0, 16'h0777);
        chk("R7 reaches threshold", int'(irq), 1);
        drive(1'b0, 1'b1, '0);
        chk("R7 self clear", int'(irq), 0);
        // R5 simultaneous push and pop
        drive(1'b1, 1'b1, 16'h0888);
        chk("R5 pair unchanged", int'(count), 4);

        // R10 clear overrides push
        clear = 1'b1; push = 1'b1; push_data = 16'h9999;
        step();
        chk("R10 count cleared", int'(count), 0);
        chk("R10 head cleared", int'(head_idx), 0);
        chk("R10 pop_data held", int'(pop_data), int'(m_out));
        drive(1'b1, 1'b0, 16'h1234);
        drive(1'b0, 1'b1, '0);
        chk("R10 pointers restart", int'(pop_data), 16'h1234);

        // constrained random phases
        for (int ph = 0; ph < 4; ph++) begin
            int pp;
            pp = (ph == 0) ? 85 : (ph == 1) ? 50 : (ph == 2) ? 15 : 55;
            last_pos = 5'($urandom % 24);
            for (int c = 0; c < 1500; c++) begin
                push      = ($urandom % 100) < pp;
                pop       = ($urandom % 100) < (100 - pp);
                push_data = 16'($urandom);
                clear     = ($urandom % 500) == 0;
                if (($urandom % 100) == 0) begin
                    thr_we = 1'b1; thr_wdata = 10'($urandom % 520);
                end
                if (($urandom % 150) == 0) begin
                    ien_we = 1'b1; ien_wdata = 1'($urandom);
                end
                step();
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule